// File: doc/BRIEF.md
# Indexed Block-Transfer Configuration Register Slave

This block is a two-wire serial slave that holds a small bank of 8-bit configuration registers for a clock-generation chip. The host reaches the bank with indexed block transfers. A write names a starting index and a byte count and then sends that many data bytes. A read names a starting index, turns the bus round with a repeated start, and receives a byte count followed by register contents. The index steps forward after every data byte and wraps to zero after the last register.

SCL and SDA come in as plain levels. They are brought into the system clock domain through a synchronizer and edge-detected there. The block drives the data line only through an open-drain pull-down enable. Every register is presented on a flat parallel bus so that the surrounding logic can use its bits directly as control signals. Two strap levels are captured while reset is held and can then be read back from register 0. Register 7 holds a fixed identity byte. Register 8 sets the byte count that a block read reports.

Top module: `smb_cfg_regbank`

## Requirements
- R1: The 8-bit address byte 0xD2 (write) and 0xD3 (read) is acknowledged by driving SDA low in the ninth clock. Any other address byte is left unacknowledged, and the block ignores the bus until the next start.
- R2: In a write transfer (0xD2, index N, count X), the index, the count and each of the first X data bytes are acknowledged. Data byte k is stored at register N+k.
- R3: A data byte sent after X bytes have already been accepted is not acknowledged and not stored. With X = 0, no data byte is accepted.
- R4: In a read transfer (0xD2, index N, repeated start, 0xD3), the block first returns the value of register 8. It then returns registers N, N+1, ... for as long as the host acknowledges.
- R5: A host not-acknowledge ends the read. SDA is released and a following transfer works normally.
- R6: Register 8 resets to 0x08, is fully writable, and its current value is the count byte that a read returns.
- R7: Register 7 reads 0x01 at all times. The low nibble is an identity code of 1 and the high nibble a revision of 0. Writes to it have no effect.
- R8: Register 0 bits 1:0 hold the strap_fs levels sampled while rst is high. Changes on strap_fs after reset have no effect, and bits 7:2 read 0.
- R9: Reset values, by index: 1=0x43, 3=0xBF, 4=0xC7, 5=0xD7, 6=0x03 (bits 4:2, the spread and frequency controls, are 0), 7=0x01, 8=0x08, all others 0x00 (register 0 apart from its strap bits).
- R10: Only these writable masks take effect, and all other bits keep their value: 1=0xC3, 2=0xD8, 3=0xBF, 4=0xC7, 5=0xF7, 6=0xBF, 8=0xFF, 10=0x80, 11=0xFF, 12=0xFF, 13=0xFF, 14=0x3F, 15=0xFF. Registers 0, 7 and 9 are not writable.
- R11: The index advances after each data byte, in both directions, and wraps from 15 to 0.
- R12: A start condition seen at any bit position restarts address reception. A stop condition returns the block to idle with SDA released.
- R13: The block changes sda_pull only while the synchronized SCL is low, so its SDA level is steady over every SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while it is high |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level (wired-AND of all drivers) |
| strap_fs | input | 2 | Frequency-select strap levels |
| cfg_flat | output | NUM_REGS*8 | All registers, register i at bits 8i+7:8i |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The assertions assume a well-formed bus. SDA moves only while SCL is low, except at start and stop conditions. Each SCL phase lasts longer than the synchronizer latency. strap_fs stays constant through reset. The bench drives SCL with phases of twenty system clocks, changes SDA in the middle of the low phase, and releases SDA whenever the slave owns the line, so the stimulus stays inside those assumptions. It also checks that no read byte is ever sampled while the block's pull-down is changing.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  typedef enum logic [2:0] {
    BS_IDLE,
    BS_RX,
    BS_RX_ACK,
    BS_TX,
    BS_TX_ACK
  } bus_state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_INDEX,
    PH_COUNT,
    PH_DATA
  } rx_phase_t;

  localparam int CNT_REG_IDX = 8;

  function automatic logic [7:0] reg_rst_val(input int idx);
    case (idx)
      1:       return 8'h43;
      3:       return 8'hBF;
      4:       return 8'hC7;
      5:       return 8'hD7;
      6:       return 8'h03;
      7:       return 8'h01;
      8:       return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reg_wr_mask(input int idx);
    case (idx)
      1:       return 8'hC3;
      2:       return 8'hD8;
      3:       return 8'hBF;
      4:       return 8'hC7;
      5:       return 8'hF7;
      6:       return 8'hBF;
      8:       return 8'hFF;
      10:      return 8'h80;
      11:      return 8'hFF;
      12:      return 8'hFF;
      13:      return 8'hFF;
      14:      return 8'h3F;
      15:      return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_sh;
  logic [STAGES-1:0] sda_sh;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[STAGES-2:0], sda_in};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // data edge while clock is steadily high marks a bus condition
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/smb_byte_engine.sv
module smb_byte_engine
  import smb_cfg_pkg::*;
#(
  parameter int         NUM_REGS = 16,
  parameter int         IDX_W    = 4,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_s,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  input  logic [7:0]       cnt_val,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_pull
);

  bus_state_t       state;
  rx_phase_t        phase;
  logic [3:0]       bitcnt;
  logic [6:0]       rx_sh;
  logic [6:0]       tx_sh;
  logic [IDX_W-1:0] idx;
  logic [7:0]       remain;
  logic             ack_pend;
  logic             tx_go;
  logic             host_ack;
  logic [7:0]       rx_byte;
  logic [IDX_W-1:0] next_idx;

  assign rx_byte  = {rx_sh, sda_s};
  assign next_idx = (idx == IDX_W'(NUM_REGS - 1)) ? '0 : idx + 1'b1;
  assign rd_idx   = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= BS_IDLE;
      phase    <= PH_ADDR;
      bitcnt   <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      idx      <= '0;
      remain   <= '0;
      ack_pend <= 1'b0;
      tx_go    <= 1'b0;
      host_ack <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
      sda_pull <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state    <= BS_RX;
        phase    <= PH_ADDR;
        bitcnt   <= '0;
        tx_go    <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        state    <= BS_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          BS_RX: begin
            if (scl_rise) begin
              rx_sh  <= rx_byte[6:0];
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == 4'd7) begin
                case (phase)
                  PH_ADDR: begin
                    if (rx_byte[7:1] == DEV_ADDR) begin
                      ack_pend <= 1'b1;
                      tx_go    <= rx_byte[0];
                      phase    <= PH_INDEX;
                    end else begin
                      ack_pend <= 1'b0;
                    end
                  end
                  PH_INDEX: begin
                    idx      <= rx_byte[IDX_W-1:0];
                    ack_pend <= 1'b1;
                    phase    <= PH_COUNT;
                  end
                  PH_COUNT: begin
                    remain   <= rx_byte;
                    ack_pend <= 1'b1;
                    phase    <= PH_DATA;
                  end
                  default: begin
                    if (remain != 8'd0) begin
                      wr_en    <= 1'b1;
                      wr_idx   <= idx;
                      wr_data  <= rx_byte;
                      idx      <= next_idx;
                      remain   <= remain - 1'b1;
                      ack_pend <= 1'b1;
                    end else begin
                      ack_pend <= 1'b0;
                    end
                  end
                endcase
              end
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (ack_pend) begin
                sda_pull <= 1'b1;
                state    <= BS_RX_ACK;
              end else begin
                state <= BS_IDLE;
              end
            end
          end
          BS_RX_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (tx_go) begin
                tx_sh    <= cnt_val[6:0];
                sda_pull <= ~cnt_val[7];
                state    <= BS_TX;
              end else begin
                sda_pull <= 1'b0;
                state    <= BS_RX;
              end
            end
          end
          BS_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_pull <= 1'b0;
                host_ack <= 1'b0;
                state    <= BS_TX_ACK;
              end else begin
                sda_pull <= ~tx_sh[6];
                tx_sh    <= {tx_sh[5:0], 1'b0};
              end
            end
          end
          BS_TX_ACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (host_ack) begin
                tx_sh    <= rd_data[6:0];
                sda_pull <= ~rd_data[7];
                idx      <= next_idx;
                bitcnt   <= '0;
                state    <= BS_TX;
              end else begin
                state <= BS_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/smb_reg_store.sv
module smb_reg_store
  import smb_cfg_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            strap_fs,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [7:0]            rd_data,
  output logic [7:0]            cnt_val,
  output logic [NUM_REGS*8-1:0] cfg_flat
);

  logic [NUM_REGS*8-1:0] cfg_w;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] RST_V = reg_rst_val(g);
    localparam logic [7:0] MSK_V = reg_wr_mask(g);
    logic [7:0] q;

    if (g == 0) begin : g_strap
      // strap levels are sampled for as long as reset is held
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= {RST_V[7:2], strap_fs};
        end else if (wr_en && wr_idx == IDX_W'(g)) begin
          q <= (q & ~MSK_V) | (wr_data & MSK_V);
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= RST_V;
        end else if (wr_en && wr_idx == IDX_W'(g)) begin
          q <= (q & ~MSK_V) | (wr_data & MSK_V);
        end
      end
    end

    assign cfg_w[g*8 +: 8] = q;
  end

  assign rd_data  = cfg_w[{rd_idx, 3'b000} +: 8];
  assign cnt_val  = cfg_w[CNT_REG_IDX*8 +: 8];
  assign cfg_flat = cfg_w;

endmodule

// File: rtl/smb_cfg_regbank.sv
module smb_cfg_regbank #(
  parameter int         NUM_REGS    = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h69
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_in,
  input  logic                  sda_in,
  input  logic [1:0]            strap_fs,
  output logic [NUM_REGS*8-1:0] cfg_flat,
  output logic                  sda_pull
);

  localparam int IDX_W = $clog2(NUM_REGS);

  logic             line_scl;
  logic             line_sda;
  logic             line_rise;
  logic             line_fall;
  logic             line_start;
  logic             line_stop;
  logic [IDX_W-1:0] rd_idx;
  logic [7:0]       rd_data;
  logic [7:0]       cnt_val;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_s     (line_scl),
    .sda_s     (line_sda),
    .scl_rise  (line_rise),
    .scl_fall  (line_fall),
    .start_det (line_start),
    .stop_det  (line_stop)
  );

  smb_byte_engine #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W),
    .DEV_ADDR (DEV_ADDR)
  ) u_engine (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (line_rise),
    .scl_fall  (line_fall),
    .sda_s     (line_sda),
    .start_det (line_start),
    .stop_det  (line_stop),
    .rd_data   (rd_data),
    .cnt_val   (cnt_val),
    .rd_idx    (rd_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .sda_pull  (sda_pull)
  );

  smb_reg_store #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .strap_fs (strap_fs),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .cnt_val  (cnt_val),
    .cfg_flat (cfg_flat)
  );

endmodule

// File: rtl/smb_cfg_regbank_chk.sv
module smb_cfg_regbank_chk #(
  parameter int NUM_REGS = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_s,
  input logic                  start_det,
  input logic                  stop_det,
  input logic                  sda_pull,
  input logic [NUM_REGS*8-1:0] cfg_flat
);

  // R13: the pull-down only moves while the sampled clock is low
  a_r13_pull_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(sda_pull) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);

  // R12: a stop always leaves the line released
  a_r12_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_pull);

  // R7: identity register never changes
  a_r7_ident_fixed: assert property (@(posedge clk) disable iff (rst)
    cfg_flat[63:56] == 8'h01);

  // R8: strap bits are frozen once reset is released
  a_r8_strap_frozen: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(cfg_flat[1:0]));

  // R6: count register leaves reset at 0x08
  a_r6_count_reset: assert property (@(posedge clk)
    $fell(rst) |-> cfg_flat[71:64] == 8'h08);

endmodule

bind smb_cfg_regbank smb_cfg_regbank_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_s     (line_scl),
  .start_det (line_start),
  .stop_det  (line_stop),
  .sda_pull  (sda_pull),
  .cfg_flat  (cfg_flat)
);

// File: tb/smb_cfg_regbank_test.sv
module smb_cfg_regbank_test;

  localparam int NREG = 16;
  localparam int HQ   = 10;

  logic            clk = 1'b0;
  logic            rst;
  logic            scl;
  logic            sda_host;
  logic [1:0]      strap;
  logic [NREG*8-1:0] cfg_flat;
  logic            sda_pull;
  wire             sda_line = sda_host & ~sda_pull;

  int checks = 0;
  int fails  = 0;
  int viol   = 0;
  bit done   = 1'b0;

  logic [7:0] mdl [NREG];
  logic [7:0] wq [$];
  logic [7:0] exp_q [$];
  logic [7:0] obs_q [$];

  always #5 clk = ~clk;

  smb_cfg_regbank uut (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl),
    .sda_in   (sda_line),
    .strap_fs (strap),
    .cfg_flat (cfg_flat),
    .sda_pull (sda_pull)
  );

  function automatic logic [7:0] spec_rst(input int i);
    case (i)
      1: return 8'h43; 3: return 8'hBF; 4: return 8'hC7; 5: return 8'hD7;
      6: return 8'h03; 7: return 8'h01; 8: return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] spec_mask(input int i);
    case (i)
      1: return 8'hC3; 2: return 8'hD8; 3: return 8'hBF; 4: return 8'hC7;
      5: return 8'hF7; 6: return 8'hBF; 8: return 8'hFF; 10: return 8'h80;
      11: return 8'hFF; 12: return 8'hFF; 13: return 8'hFF; 14: return 8'h3F;
      15: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic put_bit(input logic b);
    logic p0;
    tick(HQ); sda_host = b;
    tick(HQ); scl = 1'b1;
    tick(HQ); p0 = sda_pull;
    tick(HQ); if (sda_pull !== p0) viol++;
    scl = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    logic p0;
    tick(HQ); sda_host = 1'b1;
    tick(HQ); scl = 1'b1;
    tick(HQ); b = sda_line; p0 = sda_pull;
    tick(HQ); if (sda_pull !== p0) viol++;
    scl = 1'b0;
  endtask

  task automatic start_c();
    tick(HQ); sda_host = 1'b1;
    tick(HQ); scl = 1'b1;
    tick(HQ); sda_host = 1'b0;
    tick(HQ); scl = 1'b0;
  endtask

  task automatic stop_c();
    tick(HQ); sda_host = 1'b0;
    tick(HQ); scl = 1'b1;
    tick(HQ); sda_host = 1'b1;
    tick(HQ);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~give_ack);
  endtask

  task automatic compare_all(input string tag);
    for (int i = 0; i < NREG; i++) chk(tag, cfg_flat[i*8 +: 8], mdl[i]);
  endtask

  // block write of all bytes in wq; model updated only for accepted bytes
  task automatic blk_write(input int idx, input int cnt, input string tag);
    logic a;
    int   p;
    start_c();
    send_byte(8'hD2, a);            chk("R1 write address ack", a, 1);
    send_byte(8'(idx), a);          chk("R2 index ack", a, 1);
    send_byte(8'(cnt), a);          chk("R2 count ack", a, 1);
    p = idx;
    for (int k = 0; k < wq.size(); k++) begin
      send_byte(wq[k], a);
      chk(tag, a, (k < cnt) ? 1 : 0);
      if (k < cnt) begin
        mdl[p] = (mdl[p] & ~spec_mask(p)) | (wq[k] & spec_mask(p));
        p = (p + 1) % NREG;
      end
    end
    stop_c();
    compare_all(tag);
    wq.delete();
  endtask

  // block read: driver pushes expected bytes, monitor compares
  task automatic blk_read(input int idx, input int n);
    logic       a;
    logic [7:0] v;
    start_c();
    send_byte(8'hD2, a);            chk("R1 write address ack", a, 1);
    send_byte(8'(idx), a);          chk("R4 index ack", a, 1);
    start_c();
    send_byte(8'hD3, a);            chk("R1 read address ack", a, 1);
    exp_q.push_back(mdl[8]);
    for (int k = 0; k < n; k++) exp_q.push_back(mdl[(idx + k) % NREG]);
    for (int k = 0; k <= n; k++) begin
      recv_byte(v, k < n);
      obs_q.push_back(v);
    end
    stop_c();
    chk("R5 sda released after host nack", sda_pull, 0);
  endtask

  initial begin : monitor
    logic [7:0] o;
    logic [7:0] e;
    forever begin
      wait (obs_q.size() > 0);
      o = obs_q.pop_front();
      e = exp_q.pop_front();
      chk("R4 read byte", o, e);
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin : stim
    logic       a;
    logic [7:0] v;
    rst = 1'b1; scl = 1'b1; sda_host = 1'b1; strap = 2'b10;
    for (int i = 0; i < NREG; i++) mdl[i] = spec_rst(i);
    mdl[0] = 8'h02;
    repeat (5) @(posedge clk);
    #2 rst = 1'b0;
    tick(2);
    strap = 2'b01;
    tick(4);

    compare_all("R9 reset value");
    chk("R12 idle sda released", sda_pull, 0);
    chk("R6 count reset 0x08", cfg_flat[71:64], 8'h08);
    chk("R7 identity 0x01", cfg_flat[63:56], 8'h01);
    chk("R8 strap captured", cfg_flat[7:0], 8'h02);
    chk("R9 reg6 spread bits zero", cfg_flat[52:50], 3'b000);

    // R1: foreign address not acknowledged
    start_c();
    send_byte(8'hA0, a);
    chk("R1 foreign address nack", a, 0);
    stop_c();

    // R2: plain block write
    wq = '{8'h81, 8'hFF, 8'h3C};
    blk_write(1, 3, "R2 data ack and store");

    // R3: bytes past the count refused
    wq = '{8'hAA, 8'h55};
    blk_write(11, 1, "R3 data beyond count");
    wq = '{8'h12};
    blk_write(12, 0, "R3 zero count");

    // R4/R5: read from index 1, eight bytes
    blk_read(1, 8);

    // R6: count register writable and drives count byte
    wq = '{8'h03};
    blk_write(8, 1, "R6 count register write");
    chk("R6 count value", cfg_flat[71:64], 8'h03);
    blk_read(5, 3);

    // R10/R8/R7: read-only and reserved bits ignore writes
    wq = '{8'hFF, 8'hFF, 8'hFF};
    blk_write(0, 3, "R10 masked write");
    chk("R8 strap ignores write and pin change", cfg_flat[7:0], 8'h02);
    wq = '{8'h55, 8'h00, 8'hFF};
    blk_write(7, 3, "R10 readonly write");
    chk("R7 identity unchanged", cfg_flat[63:56], 8'h01);

    // R11: wrap in both directions
    wq = '{8'h5A, 8'hFF, 8'h00};
    blk_write(15, 3, "R11 write wrap");
    blk_read(15, 2);

    // R1: direct read address uses retained index
    start_c();
    send_byte(8'hD3, a);
    chk("R1 direct read address ack", a, 1);
    exp_q.push_back(mdl[8]);
    recv_byte(v, 1'b0);
    obs_q.push_back(v);
    stop_c();

    // R12: start in the middle of a byte restarts reception
    start_c();
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    wq = '{8'h3C};
    blk_write(13, 1, "R12 restart mid byte");
    chk("R12 released after stop", sda_pull, 0);

    wait (obs_q.size() == 0);
    tick(2);
    chk("R13 sda steady while scl high", viol, 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule